// File: doc/BRIEF.md
# Queued-Transmit SPI Master

This block is a serial peripheral interface master for byte transfers. A processor-side port loads a byte into a one-deep transmit holding register, reads back the last received byte and watches two flags: one says the holding register can take a byte, the other says a received byte is waiting. Three settings control the serial side. A rate code picks the serial clock as the bus clock divided by 2, 8, 32 or 128. A phase bit picks where data changes relative to the clock edges. A polarity bit sets the idle level of the clock. Data leaves on `mosi` and arrives on `miso`, most significant bit first, eight bits per transfer.

The bit clock comes from a prescaler that counts freely from reset and is never restarted by a write. A waiting byte therefore starts only at the next bit boundary of that prescaler, so the start delay depends on when the write lands. A byte written while a transfer is running waits in the holding register and is shifted right after the current byte, with no idle bit between the two.

The controller has two states. `ST_IDLE` holds the clock at its idle level. `ST_XFER` runs sixteen half-bit periods. The transitions are: *start* (`ST_IDLE`→`ST_XFER`, at a bit boundary with a byte waiting), *chain* (`ST_XFER`→`ST_XFER`, at the last half-bit with a byte waiting) and *finish* (`ST_XFER`→`ST_IDLE`, at the last half-bit with nothing waiting).

Top module: `spim_queued`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `mosi`=1 and `sck` equals `idle_high`.
- R2: `rate_sel` 0,1,2,3 selects a bit time D of 2, 8, 32 or 128 bus cycles. A single transfer lasts 8·D cycles, counted from the edge where `tx_empty` rises to the edge where `rx_full` rises.
- R3: The prescaler counts bus cycles freely from the first edge after reset. A transfer starts only on an edge where that count is a multiple of D. The start falls 1 to D edges after the edge that accepted the write into an idle, empty block.
- R4: Eight bits shift per transfer, most significant bit first, on `mosi` and from `miso`. The received byte appears on `rd_data`.
- R5: With `phase_sel`=0, `mosi` carries bit 7 and `sck` stays at its idle level for the first half-bit. Receive sampling happens on leading clock edges.
- R6: With `phase_sel`=1, the first leading `sck` edge occurs at the start edge and `mosi` carries bit 7 from that edge on. Receive sampling happens on trailing clock edges.
- R7: `sck` rests at the level of `idle_high` whenever no transfer runs, including after each transfer.
- R8: `tx_empty` clears on the edge that accepts a write. It sets on the edge where the held byte moves into the shifter, which is the start edge.
- R9: A byte written during a transfer starts exactly 8·D cycles after the current transfer started, back to back.
- R10: A write while the holding register is full is ignored. `tx_empty` stays 0 and the byte is never sent.
- R11: At the end of each transfer `rx_full` sets and `rd_data` takes the received byte. A one-cycle `rd_en` clears `rx_full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bit-time code: 0→2, 1→8, 2→32, 3→128 bus cycles; change only while idle |
| phase_sel | input | 1 | 0: data valid before first edge; 1: data changes on first edge |
| idle_high | input | 1 | Idle level of `sck` |
| wr_en | input | 1 | Write strobe into the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears `rx_full` |
| rd_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Holding register can accept a byte |
| rx_full | output | 1 | A received byte is waiting |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two situations are hard to reach from the ports. The first is the exact start edge, since it depends on the hidden prescaler phase. The bench keeps its own count of cycles since reset and predicts from it where each bit boundary falls. The second is the chained transfer with a third byte arriving while the holding register is still full. The bench writes the second byte on the cycle right after the start edge and the third byte one cycle later. It then checks the spacing between the two starts and that only two bytes appear on `mosi`.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int RATE_W = 2;
    localparam int PRE_W  = 2 * ((1 << RATE_W) - 1) + 1;

    typedef enum logic {
        ST_IDLE,
        ST_XFER
    } xfer_state_e;

    // log2 of the bit time in bus cycles for a rate code
    function automatic int rate_shift(input logic [RATE_W-1:0] code);
        return 2 * int'(code) + 1;
    endfunction
endpackage

// File: rtl/spim_prescaler.sv
module spim_prescaler
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              half_tick,
    output logic              bit_tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] full_mask;
    logic [PRE_W-1:0] half_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        full_mask = PRE_W'((32'd1 << rate_shift(rate_sel)) - 32'd1);
        half_mask = full_mask >> 1;
        bit_tick  = (cnt_q & full_mask) == full_mask;
        half_tick = (cnt_q & half_mask) == half_mask;
    end

    AST_BIT_HAS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> half_tick); // R2
endmodule

// File: rtl/spim_txbuf.sv
module spim_txbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            if (wr_en && !valid) begin
                valid <= 1'b1;
                data  <= wr_data;
            end
            if (pop) valid <= 1'b0;
        end
    end

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(data))); // R10
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> valid); // R8
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              bit_tick,
    input  logic              phase_sel,
    input  logic              idle_high,
    input  logic              buf_valid,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              miso,
    output logic              pop,
    output logic              xfer_done,
    output logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              sck,
    output logic              mosi
);
    localparam int              HALF_W    = $clog2(2 * DATA_W);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * DATA_W - 1);

    xfer_state_e       state_q, state_d;
    logic [HALF_W-1:0] half_q;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              last_half;

    assign last_half = half_tick && (half_q == HALF_LAST);

    // next state: start, chain, finish
    always_comb begin
        state_d   = state_q;
        pop       = 1'b0;
        xfer_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_tick && buf_valid) begin
                    pop     = 1'b1;
                    state_d = ST_XFER;
                end
            end
            ST_XFER: begin
                if (last_half) begin
                    xfer_done = 1'b1;
                    if (buf_valid) pop = 1'b1;
                    else           state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shifters and half-bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else begin
            if (state_q == ST_XFER && half_tick) begin
                half_q <= last_half ? '0 : half_q + 1'b1;
                if (!half_q[0]) rx_sh <= {rx_sh[DATA_W-2:0], miso};
                else            tx_sh <= tx_sh << 1;
            end
            if (pop) begin
                tx_sh  <= buf_data;
                half_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                sck  = idle_high;
                mosi = 1'b1;
            end
            ST_XFER: begin
                sck  = idle_high ^ (phase_sel ? ~half_q[0] : half_q[0]);
                mosi = tx_sh[DATA_W-1];
            end
        endcase
    end

    assign rx_word = rx_sh;
    assign busy    = (state_q == ST_XFER);

    AST_END_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> bit_tick); // R9
    AST_IDLE_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (half_q == '0)); // R7
endmodule

// File: rtl/spim_queued.sv
module spim_queued
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              phase_sel,
    input  logic              idle_high,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    logic              half_tick, bit_tick;
    logic              buf_valid, pop, xfer_done, busy;
    logic [DATA_W-1:0] buf_data, rx_word, rx_q;
    logic              rx_full_q;

    spim_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .half_tick(half_tick), .bit_tick(bit_tick)
    );

    spim_txbuf #(.DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pop(pop), .valid(buf_valid), .data(buf_data)
    );

    spim_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .bit_tick(bit_tick),
        .phase_sel(phase_sel), .idle_high(idle_high),
        .buf_valid(buf_valid), .buf_data(buf_data), .miso(miso),
        .pop(pop), .xfer_done(xfer_done), .rx_word(rx_word), .busy(busy),
        .sck(sck), .mosi(mosi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q      <= '0;
            rx_full_q <= 1'b0;
        end else if (xfer_done) begin
            rx_q      <= rx_word;
            rx_full_q <= 1'b1;
        end else if (rd_en) begin
            rx_full_q <= 1'b0;
        end
    end

    assign rd_data  = rx_q;
    assign rx_full  = rx_full_q;
    assign tx_empty = !buf_valid;

    AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bit_tick)); // R3
    AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> rx_full); // R11
endmodule

// File: tb/spim_queued_test.sv
`timescale 1ns/1ps
module spim_queued_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       phase_sel = 1'b0;
    logic       idle_high = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, sck, mosi, miso;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    spim_queued uut (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .phase_sel(phase_sel),
        .idle_high(idle_high), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .tx_empty(tx_empty), .rx_full(rx_full),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #4 clk = ~clk;

    // cycles since reset, mirrors the free-running prescaler count
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // slave model and mosi capture
    logic [7:0] sq [0:3];
    logic [7:0] sreg = 8'hFF;
    logic [7:0] mcap = 8'h00;
    logic [7:0] got [0:3];
    int sidx = 0, sbits = 0, mcnt = 0, got_n = 0;
    bit sampled = 1'b0;
    bit mon_en = 1'b0;

    assign miso = sreg[7];

    always @(sck) begin
        if (rst_n && mon_en) begin
            if ((sck != idle_high) == (phase_sel == 1'b0)) begin
                mcap = {mcap[6:0], mosi};
                mcnt++;
                sbits++;
                sampled = 1'b1;
                if (mcnt == 8) begin
                    if (got_n < 4) got[got_n] = mcap;
                    got_n++;
                    mcnt = 0;
                end
            end else if (sampled) begin
                sampled = 1'b0;
                if (sbits == 8) begin
                    sidx++;
                    sreg  = sq[sidx % 4];
                    sbits = 0;
                end else begin
                    sreg = {sreg[6:0], 1'b0};
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic slave_prep(input logic [7:0] a, input logic [7:0] b);
        mon_en  = 1'b0;
        sq[0] = a; sq[1] = b; sq[2] = 8'h00; sq[3] = 8'h00;
        sidx = 0; sreg = a; sbits = 0; sampled = 1'b0;
        mcnt = 0; got_n = 0;
        mon_en  = 1'b1;
    endtask

    task automatic set_cfg(input logic [1:0] r, input bit p, input bit pol);
        @(negedge clk);
        mon_en = 1'b0;
        rate_sel = r; phase_sel = p; idle_high = pol;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_data = b;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_pulse();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_start(output int d);
        d = 0;
        while (!tx_empty && d < 400) begin
            @(negedge clk);
            d++;
        end
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        idle_high = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
        chk(rx_full == 1'b0, "R1 rx_full", int'(rx_full), 0);
        chk(sck == 1'b0, "R1 sck", int'(sck), 0);
        chk(mosi == 1'b1, "R1 mosi", int'(mosi), 1);
        idle_high = 1'b1;
        @(negedge clk);
        chk(sck == 1'b1, "R7 idle high", int'(sck), 1);
        idle_high = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_single(input logic [1:0] r, input bit p, input bit pol,
                               input logic [7:0] tb, input logic [7:0] sb);
        int D = 2 << (2 * r);
        int d;
        int m;
        set_cfg(r, p, pol);
        slave_prep(sb, 8'h00);
        chk(sck == pol, "R7 idle before", int'(sck), int'(pol));
        write_byte(tb);
        chk(tx_empty == 1'b0, "R8 clear on write", int'(tx_empty), 0);
        wait_start(d);
        chk(d >= 1 && d <= D, "R3 start delay", d, D);
        chk((cyc % D) == 0, "R3 boundary", cyc % D, 0);
        if (p) begin
            chk(sck != pol, "R6 first edge at start", int'(sck), int'(!pol));
            chk(mosi == tb[7], "R6 msb at start", int'(mosi), int'(tb[7]));
        end else begin
            chk(sck == pol, "R5 idle first half", int'(sck), int'(pol));
            chk(mosi == tb[7], "R5 msb before edge", int'(mosi), int'(tb[7]));
        end
        m = 0;
        while (!rx_full && m < 2000) begin
            @(negedge clk);
            m++;
        end
        chk(m == 8 * D, "R2 transfer length", m, 8 * D);
        chk(rd_data == sb, "R4 received byte", int'(rd_data), int'(sb));
        chk(got_n == 1 && got[0] == tb, "R4 sent byte", int'(got[0]), int'(tb));
        chk(tx_empty == 1'b1, "R8 empty after", int'(tx_empty), 1);
        chk(sck == pol, "R7 idle after", int'(sck), int'(pol));
        read_pulse();
        chk(rx_full == 1'b0, "R11 read clears", int'(rx_full), 0);
    endtask

    task automatic test_queue(input bit p, input bit pol);
        int D = 8;
        int d;
        int m;
        set_cfg(2'd1, p, pol);
        slave_prep(8'hC6, 8'h39);
        write_byte(8'h96);
        wait_start(d);
        chk((cyc % D) == 0, "R3 queue boundary", cyc % D, 0);
        write_byte(8'h4B);
        chk(tx_empty == 1'b0, "R8 queued", int'(tx_empty), 0);
        write_byte(8'hE1);
        chk(tx_empty == 1'b0, "R10 full stays", int'(tx_empty), 0);
        m = 2;
        while (!tx_empty && m < 2000) begin
            @(negedge clk);
            m++;
        end
        chk(m == 8 * D, "R9 back to back", m, 8 * D);
        chk(rx_full == 1'b1, "R11 first done", int'(rx_full), 1);
        chk(rd_data == 8'hC6, "R11 first data", int'(rd_data), 8'hC6);
        read_pulse();
        chk(rx_full == 1'b0, "R11 clear mid", int'(rx_full), 0);
        m = 1;
        while (!rx_full && m < 2000) begin
            @(negedge clk);
            m++;
        end
        chk(m == 8 * D, "R9 second length", m, 8 * D);
        chk(rd_data == 8'h39, "R4 second data", int'(rd_data), 8'h39);
        repeat (3 * 8 * D) @(negedge clk);
        chk(got_n == 2, "R10 byte count", got_n, 2);
        chk(got[0] == 8'h96, "R9 first sent", int'(got[0]), 8'h96);
        chk(got[1] == 8'h4B, "R9 second sent", int'(got[1]), 8'h4B);
        chk(tx_empty == 1'b1 && sck == pol, "R10 idle after", int'(sck), int'(pol));
        read_pulse();
    endtask

    initial begin
        test_reset();
        test_single(2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C);
        test_single(2'd1, 1'b1, 1'b0, 8'h81, 8'h7E);
        test_single(2'd2, 1'b0, 1'b1, 8'hF0, 8'h0F);
        test_single(2'd3, 1'b1, 1'b1, 8'h5A, 8'hC3);
        test_single(2'd1, 1'b0, 1'b0, 8'h01, 8'h80);
        test_queue(1'b0, 1'b0);
        test_queue(1'b1, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule